// File: doc/BRIEF.md
# Endpoint DMA Request Flag Bank

This block keeps one DMA request flag per USB endpoint in a vector indexed by physical endpoint number. The endpoint datapath reports packet arrivals and the DMA engine reports finished transfers. The block turns these events into flags that stay set until the transfer is done. Two per-endpoint inputs qualify the hardware events. A DMA-enable vector marks the endpoints that run in DMA mode. A slave-mode interrupt-enable vector suppresses the hardware request while software still handles that endpoint directly.

Software reaches the vector through a small register bus with three views: a read-only status word, a word where writing ones sets flags, and a word where writing ones clears flags. The set word lets software start a transfer by hand when a packet arrived before the interrupt enable was dropped. The clear word prepares the flags before DMA is switched on. The two control-endpoint positions are fixed at zero.

Each flag position is a two-state machine. The states are `FLAG_IDLE` (no request) and `FLAG_PEND` (request pending). Transition RAISE goes from `FLAG_IDLE` to `FLAG_PEND` on any set source. Transition DROP goes from `FLAG_PEND` to `FLAG_IDLE` on a clear source when no set source is active in the same cycle. In every other case the state holds.

Top module: `dmareq_bank`

## Requirements
- R1: A bus write to address 2 clears every flag whose data bit is 1 on the next clock edge; data bits that are 0 leave their flags unchanged.
- R2: A bus write to address 1 sets every flag at positions 2..31 whose data bit is 1 on the next clock edge; data bits that are 0 leave their flags unchanged.
- R3: Flag positions 0 and 1 (control endpoint OUT and IN) read as 0 at all times, whatever writes or hardware events occur.
- R4: With address 0 on the bus, `reg_rdata` shows the flag vector, where bit i is endpoint i and 1 means a request is pending.
- R5: A `xfer_done` pulse on bit i clears flag i on the next edge when `dma_en[i]` is 1; when `dma_en[i]` is 0 the pulse is ignored.
- R6: A `pkt_arrive` pulse on bit i sets flag i on the next edge when `dma_en[i]` is 1 and `slave_irq_en[i]` is 0.
- R7: A `pkt_arrive` pulse is ignored for an endpoint whose `slave_irq_en` bit is 1 or whose `dma_en` bit is 0.
- R8: All flags are 0 while reset is asserted and right after it is released.
- R9: Reads at addresses 1, 2 and 3 return 0; writes to address 3 change no flag.
- R10: When a set source (bus set or qualified packet arrival) and a clear source (bus clear or qualified transfer completion) hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 status, 1 set, 2 clear, 3 unused |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data, one bit per endpoint |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| pkt_arrive | input | 32 | Packet-arrival pulse for each endpoint |
| xfer_done | input | 32 | Transfer-complete pulse for each endpoint from the DMA engine |
| slave_irq_en | input | 32 | Slave-mode interrupt enable for each endpoint |
| dma_en | input | 32 | DMA mode enable for each endpoint |
| dma_req | output | 32 | Current request flag vector |

## Verification
The assertions check every cycle that the control positions stay zero, that set and clear writes reach their flags one edge later, and that qualified hardware events take effect. They also check that blocked arrivals leave idle flags idle, that set beats clear, and that the read mux returns the status word or zero. The reset value, the fact that zero data bits leave flags unchanged, and writes to the unused address can only be shown by the bench scenarios. Those scenarios compare the whole vector against a behavioural model on every clock, through directed sequences and a random phase.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_SET    = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CLR    = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_NONE   = 2'd3;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/dmareq_regif.sv
module dmareq_regif
    import dmareq_pkg::*;
#(
    parameter int NUM_EP = 32
) (
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NUM_EP-1:0] reg_wdata,
    input  logic [NUM_EP-1:0] status,
    output logic [NUM_EP-1:0] sw_set,
    output logic [NUM_EP-1:0] sw_clr,
    output logic [NUM_EP-1:0] reg_rdata
);

    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                ADDR_SET:    sw_set = reg_wdata;
                ADDR_CLR:    sw_clr = reg_wdata;
                ADDR_STATUS,
                ADDR_NONE:   ;
            endcase
        end
    end

    // Only the status view is readable; the command views return zero.
    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata = status;
            ADDR_SET,
            ADDR_CLR,
            ADDR_NONE:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmareq_evgate.sv
module dmareq_evgate #(
    parameter int NUM_EP = 32
) (
    input  logic [NUM_EP-1:0] pkt_arrive,
    input  logic [NUM_EP-1:0] xfer_done,
    input  logic [NUM_EP-1:0] slave_irq_en,
    input  logic [NUM_EP-1:0] dma_en,
    output logic [NUM_EP-1:0] hw_set,
    output logic [NUM_EP-1:0] hw_clr
);

    // Arrival raises a request only for DMA endpoints no longer served in slave mode.
    always_comb begin
        hw_set = pkt_arrive & dma_en & ~slave_irq_en;
        hw_clr = xfer_done & dma_en;
    end

endmodule

// File: rtl/dmareq_flag.sv
module dmareq_flag
    import dmareq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_any,
    input  logic clr_any,
    output logic req
);

    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_any) state_d = FLAG_PEND;               // RAISE
            FLAG_PEND: if (clr_any && !set_any) state_d = FLAG_IDLE;   // DROP
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_IDLE: req = 1'b0;
            FLAG_PEND: req = 1'b1;
        endcase
    end

endmodule

// File: rtl/dmareq_bank.sv
module dmareq_bank
    import dmareq_pkg::*;
#(
    parameter int NUM_EP   = 32,
    parameter int NUM_CTRL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NUM_EP-1:0] reg_wdata,
    output logic [NUM_EP-1:0] reg_rdata,
    input  logic [NUM_EP-1:0] pkt_arrive,
    input  logic [NUM_EP-1:0] xfer_done,
    input  logic [NUM_EP-1:0] slave_irq_en,
    input  logic [NUM_EP-1:0] dma_en,
    output logic [NUM_EP-1:0] dma_req
);

    logic [NUM_EP-1:0] sw_set, sw_clr, hw_set, hw_clr;

    dmareq_regif #(.NUM_EP(NUM_EP)) u_regif (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .status    (dma_req),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .reg_rdata (reg_rdata)
    );

    dmareq_evgate #(.NUM_EP(NUM_EP)) u_evgate (
        .pkt_arrive   (pkt_arrive),
        .xfer_done    (xfer_done),
        .slave_irq_en (slave_irq_en),
        .dma_en       (dma_en),
        .hw_set       (hw_set),
        .hw_clr       (hw_clr)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        if (i < NUM_CTRL) begin : g_ctrl
            assign dma_req[i] = 1'b0;
        end else begin : g_data
            dmareq_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_any (sw_set[i] | hw_set[i]),
                .clr_any (sw_clr[i] | hw_clr[i]),
                .req     (dma_req[i])
            );
        end
    end

    logic unused_ctrl;
    assign unused_ctrl = ^{sw_set[NUM_CTRL-1:0], sw_clr[NUM_CTRL-1:0],
                           hw_set[NUM_CTRL-1:0], hw_clr[NUM_CTRL-1:0]};

endmodule

// File: rtl/dmareq_bank_chk.sv
module dmareq_bank_chk
    import dmareq_pkg::*;
#(
    parameter int NUM_EP   = 32,
    parameter int NUM_CTRL = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr,
    input logic [NUM_EP-1:0] reg_wdata,
    input logic [NUM_EP-1:0] reg_rdata,
    input logic [NUM_EP-1:0] pkt_arrive,
    input logic [NUM_EP-1:0] xfer_done,
    input logic [NUM_EP-1:0] slave_irq_en,
    input logic [NUM_EP-1:0] dma_en,
    input logic [NUM_EP-1:0] dma_req
);

    localparam logic [NUM_EP-1:0] HI = {{(NUM_EP-NUM_CTRL){1'b1}}, {NUM_CTRL{1'b0}}};

    logic [NUM_EP-1:0] c_hwset, c_hwclr, c_swset, c_swclr, c_block;
    assign c_hwset = pkt_arrive & dma_en & ~slave_irq_en;
    assign c_hwclr = xfer_done & dma_en;
    assign c_swset = (reg_wr && reg_addr == ADDR_SET) ? reg_wdata : '0;
    assign c_swclr = (reg_wr && reg_addr == ADDR_CLR) ? reg_wdata : '0;
    assign c_block = pkt_arrive & (slave_irq_en | ~dma_en);

    p_sw_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_swclr != '0) |=> ((dma_req & $past(c_swclr & ~c_hwset)) == '0));

    p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_swset != '0) |=> ((dma_req & $past(c_swset) & HI) == ($past(c_swset) & HI)));

    p_ctrl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req[NUM_CTRL-1:0] == '0);

    p_rd_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STATUS) |-> (reg_rdata == dma_req));

    p_hw_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hwclr != '0) |=> ((dma_req & $past(c_hwclr & ~c_hwset & ~c_swset)) == '0));

    p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hwset != '0) |=> ((dma_req & $past(c_hwset) & HI) == ($past(c_hwset) & HI)));

    p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_block != '0) |=>
        ((dma_req & $past(c_block & ~c_hwset & ~c_swset & ~dma_req)) == '0));

    p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_STATUS) |-> (reg_rdata == '0));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (((c_hwset | c_swset) & (c_hwclr | c_swclr) & HI) != '0) |=>
        ((dma_req & $past((c_hwset | c_swset) & (c_hwclr | c_swclr) & HI))
          == $past((c_hwset | c_swset) & (c_hwclr | c_swclr) & HI)));

endmodule

bind dmareq_bank dmareq_bank_chk #(.NUM_EP(NUM_EP), .NUM_CTRL(NUM_CTRL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .pkt_arrive   (pkt_arrive),
    .xfer_done    (xfer_done),
    .slave_irq_en (slave_irq_en),
    .dma_en       (dma_en),
    .dma_req      (dma_req)
);

// File: tb/sim_dmareq_bank.sv
module sim_dmareq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pkt_arrive = '0;
    logic [31:0] xfer_done = '0;
    logic [31:0] slave_irq_en = '0;
    logic [31:0] dma_en = '0;
    logic [31:0] dma_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R8";
    bit    running = 1'b0;
    bit    done    = 1'b0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    dmareq_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_arrive(pkt_arrive),
        .xfer_done(xfer_done), .slave_irq_en(slave_irq_en), .dma_en(dma_en),
        .dma_req(dma_req)
    );

    // Behavioural reference: per endpoint, any set source wins, else any clear source.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model <= '0;
        end else begin
            logic [31:0] nxt;
            nxt = model;
            for (int i = 2; i < 32; i++) begin
                bit s, c;
                s = (reg_wr && reg_addr == 2'd1 && reg_wdata[i]) ||
                    (pkt_arrive[i] && dma_en[i] && !slave_irq_en[i]);
                c = (reg_wr && reg_addr == 2'd2 && reg_wdata[i]) ||
                    (xfer_done[i] && dma_en[i]);
                if (s)      nxt[i] = 1'b1;
                else if (c) nxt[i] = 1'b0;
            end
            model <= nxt;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (running && rst_n) begin
            check(cur_req, dma_req, model);
            check("R3", {30'd0, dma_req[1:0]}, 32'd0);
            check(reg_addr == 2'd0 ? "R4" : "R9", reg_rdata,
                  reg_addr == 2'd0 ? model : 32'd0);
        end
    end

    task automatic cyc(input logic [1:0] a, input logic w, input logic [31:0] d,
                       input logic [31:0] pk, input logic [31:0] xd);
        @(negedge clk);
        #1;
        reg_addr = a; reg_wr = w; reg_wdata = d; pkt_arrive = pk; xfer_done = xd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(2'd0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #2;
        check("R8", dma_req, 32'd0);
        repeat (3) @(posedge clk);
        check("R8", dma_req, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        running = 1'b1;
        idle(1);
        @(negedge clk); check("R8", dma_req, 32'd0);

        cur_req = "R2";
        cyc(2'd1, 1'b1, 32'hFFFF_FFFF, '0, '0); idle(1);
        @(negedge clk); check("R2", dma_req, 32'hFFFF_FFFC);
        cyc(2'd1, 1'b1, 32'h0, '0, '0); idle(1);
        @(negedge clk); check("R2", dma_req, 32'hFFFF_FFFC);

        cur_req = "R1";
        cyc(2'd2, 1'b1, 32'h0000_00F3, '0, '0); idle(1);
        @(negedge clk); check("R1", dma_req, 32'hFFFF_FF0C);
        cyc(2'd2, 1'b1, 32'h0, '0, '0); idle(1);
        @(negedge clk); check("R1", dma_req, 32'hFFFF_FF0C);
        cyc(2'd2, 1'b1, 32'hFFFF_FFFF, '0, '0); idle(1);
        @(negedge clk); check("R1", dma_req, 32'h0);

        cur_req = "R9";
        cyc(2'd3, 1'b1, 32'hFFFF_FFFF, '0, '0); idle(1);
        @(negedge clk); check("R9", dma_req, 32'h0);
        cyc(2'd1, 1'b0, '0, '0, '0);
        @(negedge clk); check("R9", reg_rdata, 32'h0);
        cyc(2'd3, 1'b0, '0, '0, '0);
        @(negedge clk); check("R9", reg_rdata, 32'h0);

        cur_req = "R7";
        dma_en = 32'h0000_FFFF; slave_irq_en = 32'h0000_0F00;
        cyc(2'd0, 1'b0, '0, 32'hFFFF_0F00, '0); idle(1);
        @(negedge clk); check("R7", dma_req, 32'h0);

        cur_req = "R6";
        cyc(2'd0, 1'b0, '0, 32'hFFFF_F0F3, '0); idle(1);
        @(negedge clk); check("R6", dma_req, 32'h0000_F0F0);
        @(negedge clk); check("R4", reg_rdata, 32'h0000_F0F0);

        cur_req = "R5";
        dma_en = 32'h0000_0FFF;
        cyc(2'd0, 1'b0, '0, '0, 32'hFFFF_00F0); idle(1);
        @(negedge clk); check("R5", dma_req, 32'h0000_F000);

        cur_req = "R10";
        dma_en = 32'hFFFF_FFFF; slave_irq_en = '0;
        cyc(2'd2, 1'b1, 32'h0000_F000, 32'h0000_8000, '0); idle(1);
        @(negedge clk); check("R10", dma_req, 32'h0000_8000);
        cyc(2'd1, 1'b1, 32'h0000_8000, '0, 32'h0000_8000); idle(1);
        @(negedge clk); check("R10", dma_req, 32'h0000_8000);
        cyc(2'd0, 1'b0, '0, 32'h0000_8000, 32'h0000_8000); idle(1);
        @(negedge clk); check("R10", dma_req, 32'h0000_8000);

        cur_req = "R3";
        cyc(2'd1, 1'b1, 32'h3, 32'h3, '0); idle(1);
        @(negedge clk); check("R3", {30'd0, dma_req[1:0]}, 32'h0);

        cur_req = "R6";
        for (int n = 0; n < 400; n++) begin
            logic [31:0] sel;
            sel = $urandom;
            dma_en = $urandom; slave_irq_en = $urandom & $urandom;
            cyc(sel[1:0], sel[2], $urandom, $urandom & $urandom, $urandom & $urandom);
        end
        idle(2);
        running = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule